// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block runs a single read or write cycle on an external asynchronous static memory (SRAM, ROM or NOR-style flash). A requester presents an address, write data, a direction bit and a one-cycle start pulse. The block then walks the memory through an address-setup phase, an optional address-hold phase and a data phase. It drives chip select, output enable, write enable, address valid, the address bus and a data bus with a separate output-enable. It also captures read data. Every phase length is counted in kernel clock cycles and taken from runtime fields, which are latched when the access starts.

The phase structure depends on the access style. An extended-timing enable selects between basic timing and four extended modes (A, B, C, D). A multiplexed flag places the address on the data bus during the address phases. A pseudo-static flag marks the device as PSRAM. These inputs decide whether an address-hold phase exists and whether a zero setup length is allowed. A controller that owns the external bus instantiates one sequencer per access port. It starts an access whenever `busy` is low and collects `rdata` when `done` pulses.

States: `ST_IDLE`, `ST_SETUP`, `ST_HOLD`, `ST_DATA`, `ST_END`. Transitions:
- idle-to-setup: start with a non-zero effective setup.
- idle-to-hold: start with zero setup and a hold phase.
- idle-to-data: start with zero setup and no hold phase.
- setup-to-hold: setup count expired and a hold phase is present.
- setup-to-data: setup count expired and there is no hold phase.
- hold-to-data: hold count expired.
- data-to-end: data count expired.
- end-to-idle: unconditional.

Top module: `asm_access_seq`

## Requirements
- R1: After reset `cs_n`, `oe_n`, `we_n` and `adv_n` are 1, `busy`, `done` and `dq_oe` are 0, and `rdata` is 0. Whenever `busy` is low, all strobes stay inactive and `dq_oe` is 0.
- R2: The setup phase lasts `setup_cyc` cycles, and `adv_n` is low exactly during it. With extended timing on (`ext_mode_en`=1), mode A, B or C, no multiplexing and no PSRAM, a value of 0 skips the setup phase entirely.
- R3: A `setup_cyc` of 0 gives a one-cycle setup phase when any of these holds: multiplexing, mode D, basic timing (`ext_mode_en`=0), or PSRAM.
- R4: `mode_sel` encodes 0 as mode A, 1 as B, 2 as C and 3 as D. An address-hold phase of `hold_cyc` cycles follows setup only when `mux_en`=1, or when `ext_mode_en`=1 with `mode_sel`=3. A `hold_cyc` of 0 counts as 1. During hold, `cs_n` is low and all other strobes are high.
- R5: The data phase lasts `data_cyc` cycles, with 0 counted as 1. In a read (`wr_en`=0), `oe_n` is low for exactly the data phase. In a write (`wr_en`=1), `we_n` is low for exactly the data phase. The two are never low together.
- R6: `cs_n` goes low in the first cycle after the start edge and stays low through setup, hold and data. In the next cycle `cs_n` is high and `done` pulses for one cycle, so `done` is seen in cycle S+H+D after the start edge, counting from 0.
- R7: In a read, `dq_oe` is 0 during the data phase. `rdata` takes the `dq_in` value present in the last data-phase cycle and holds it until the next read completes.
- R8: In a write, `dq_oe` is 1 and `dq_out` equals the requested write data for exactly the data phase. The bus is released when `cs_n` rises.
- R9: With `mux_en`=1, `dq_oe` is 1 and `dq_out` carries the low address bits during setup and hold. `mem_addr` shows the requested address for the whole access.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle. A start pulse while `busy` is high is ignored: the access runs unchanged and no second access follows.
- R11: With `ext_mode_en`=0, `mode_sel` has no effect on any output timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an access |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Request address |
| wdata | input | DW | Request write data |
| ext_mode_en | input | 1 | Enables the extended mode field |
| mode_sel | input | 2 | Extended mode: 0 A, 1 B, 2 C, 3 D |
| mux_en | input | 1 | Address/data multiplexed bus |
| psram_en | input | 1 | Device is pseudo-static |
| setup_cyc | input | 4 | Address-setup length |
| hold_cyc | input | 4 | Address-hold length |
| data_cyc | input | 8 | Data-phase length |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| adv_n | output | 1 | Address valid, active low |
| mem_addr | output | AW | Memory address bus |
| dq_out | output | DW | Data bus drive value |
| dq_oe | output | 1 | Data bus drive enable (tristate control) |
| dq_in | input | DW | Data bus sampled value |

## Verification
The assertions assume that `start` is a synchronous single-cycle pulse. They also assume that the timing fields, mode inputs and request data are stable in the cycle `start` is sampled while idle. The bench changes these inputs only on falling edges, and it holds them from the start pulse onward. It deliberately raises `start` again during the second cycle or the end cycle of an access, which exercises the busy-ignore rule. It also changes `addr` at that moment and drives a different `dq_in` value in every cycle, so that a capture in the wrong cycle or a mis-latched address shows up at the ports.

// File: rtl/asm_pkg.sv
package asm_pkg;
    localparam int SET_W  = 4;
    localparam int HLD_W  = 4;
    localparam int DAT_W  = 8;
    localparam int MODE_W = 2;
    localparam int CNT_W  = DAT_W;

    localparam logic [MODE_W-1:0] MODE_D = MODE_W'(3);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HOLD,
        ST_DATA,
        ST_END
    } asm_state_e;

    typedef struct packed {
        logic [SET_W-1:0] setup_len;
        logic [HLD_W-1:0] hold_len;
        logic [DAT_W-1:0] data_len;
        logic             hold_on;
        logic             mux;
        logic             wr;
    } asm_timing_t;
endpackage

// File: rtl/asm_phase_cfg.sv
module asm_phase_cfg
    import asm_pkg::*;
(
    input  logic              ext_mode_en,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              mux_en,
    input  logic              psram_en,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  setup_cyc,
    input  logic [HLD_W-1:0]  hold_cyc,
    input  logic [DAT_W-1:0]  data_cyc,
    output asm_timing_t       timing
);
    logic hold_need;
    logic setup_min_one;

    always_comb begin
        hold_need     = mux_en || (ext_mode_en && (mode_sel == MODE_D));
        setup_min_one = hold_need || !ext_mode_en || psram_en;

        timing.setup_len = (setup_min_one && (setup_cyc == '0)) ? SET_W'(1) : setup_cyc;
        timing.hold_on   = hold_need;
        if (!hold_need) begin
            timing.hold_len = '0;
        end else if (hold_cyc == '0) begin
            timing.hold_len = HLD_W'(1);
        end else begin
            timing.hold_len = hold_cyc;
        end
        timing.data_len = (data_cyc == '0) ? DAT_W'(1) : data_cyc;
        timing.mux      = mux_en;
        timing.wr       = wr_en;
    end
endmodule

// File: rtl/asm_phase_cnt.sv
module asm_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         cnt_zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/asm_access_seq.sv
module asm_access_seq
    import asm_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              ext_mode_en,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              mux_en,
    input  logic              psram_en,
    input  logic [SET_W-1:0]  setup_cyc,
    input  logic [HLD_W-1:0]  hold_cyc,
    input  logic [DAT_W-1:0]  data_cyc,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     rdata,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              adv_n,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    input  logic [DW-1:0]     dq_in
);
    localparam int MUX_W = (AW < DW) ? AW : DW;

    asm_state_e  state_q, state_d;
    asm_timing_t tim_live, tim_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    rdata_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             accept;

    asm_phase_cfg u_cfg (
        .ext_mode_en (ext_mode_en),
        .mode_sel    (mode_sel),
        .mux_en      (mux_en),
        .psram_en    (psram_en),
        .wr_en       (wr_en),
        .setup_cyc   (setup_cyc),
        .hold_cyc    (hold_cyc),
        .data_cyc    (data_cyc),
        .timing      (tim_live)
    );

    asm_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .cnt_zero (cnt_zero)
    );

    assign accept = (state_q == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and read-data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                tim_q   <= tim_live;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if ((state_q == ST_DATA) && cnt_zero && !tim_q.wr) begin
                rdata_q <= dq_in;
            end
        end
    end

    // next state and phase counter loading
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cnt_load = 1'b1;
                    if (tim_live.setup_len != '0) begin
                        state_d = ST_SETUP;
                        cnt_val = CNT_W'(tim_live.setup_len) - CNT_W'(1);
                    end else if (tim_live.hold_on) begin
                        state_d = ST_HOLD;
                        cnt_val = CNT_W'(tim_live.hold_len) - CNT_W'(1);
                    end else begin
                        state_d = ST_DATA;
                        cnt_val = tim_live.data_len - CNT_W'(1);
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    cnt_load = 1'b1;
                    if (tim_q.hold_on) begin
                        state_d = ST_HOLD;
                        cnt_val = CNT_W'(tim_q.hold_len) - CNT_W'(1);
                    end else begin
                        state_d = ST_DATA;
                        cnt_val = tim_q.data_len - CNT_W'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    cnt_load = 1'b1;
                    state_d  = ST_DATA;
                    cnt_val  = tim_q.data_len - CNT_W'(1);
                end
            end
            ST_DATA: begin
                if (cnt_zero) begin
                    state_d = ST_END;
                end
            end
            ST_END: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        cs_n     = 1'b0;
        oe_n     = 1'b1;
        we_n     = 1'b1;
        adv_n    = 1'b1;
        dq_oe    = 1'b0;
        dq_out   = '0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                cs_n = 1'b1;
            end
            ST_SETUP: begin
                adv_n = 1'b0;
                if (tim_q.mux) begin
                    dq_oe  = 1'b1;
                    dq_out = DW'(addr_q[MUX_W-1:0]);
                end
            end
            ST_HOLD: begin
                if (tim_q.mux) begin
                    dq_oe  = 1'b1;
                    dq_out = DW'(addr_q[MUX_W-1:0]);
                end
            end
            ST_DATA: begin
                if (tim_q.wr) begin
                    we_n   = 1'b0;
                    dq_oe  = 1'b1;
                    dq_out = wdata_q;
                end else begin
                    oe_n = 1'b0;
                end
            end
            ST_END: begin
                cs_n = 1'b1;
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
                cs_n = 1'b1;
            end
        endcase
    end

    assign mem_addr = addr_q;
    assign rdata    = rdata_q;
endmodule

// File: rtl/asm_access_seq_chk.sv
module asm_access_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic cs_n,
    input logic oe_n,
    input logic we_n,
    input logic adv_n,
    input logic dq_oe
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && oe_n && we_n && adv_n && !dq_oe && !done));

    a_r2_adv_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_n |-> (!cs_n && oe_n && we_n));

    a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    a_r6_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && busy));

    a_r6_done_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!cs_n));

    a_r7_read_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !dq_oe);

    a_r8_write_bus_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (dq_oe && !cs_n));

    a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r10_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

bind asm_access_seq asm_access_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .cs_n  (cs_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .adv_n (adv_n),
    .dq_oe (dq_oe)
);

// File: tb/tb_asm_access_seq.sv
module tb_asm_access_seq;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          ext_mode_en;
    logic [1:0]    mode_sel;
    logic          mux_en;
    logic          psram_en;
    logic [3:0]    setup_cyc;
    logic [3:0]    hold_cyc;
    logic [7:0]    data_cyc;
    logic          busy, done, cs_n, oe_n, we_n, adv_n, dq_oe;
    logic [DW-1:0] rdata, dq_out, dq_in;
    logic [AW-1:0] mem_addr;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;
    int  txn_idx = 0;

    always #5 clk = ~clk;

    asm_access_seq #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .ext_mode_en(ext_mode_en), .mode_sel(mode_sel),
        .mux_en(mux_en), .psram_en(psram_en), .setup_cyc(setup_cyc),
        .hold_cyc(hold_cyc), .data_cyc(data_cyc), .busy(busy), .done(done),
        .rdata(rdata), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .adv_n(adv_n),
        .mem_addr(mem_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_txn(input bit ext, input logic [1:0] md, input bit mx, input bit ps,
                           input int s, input int h, input int d, input bit w);
        bit hold_on, min_one;
        int se, he, de, t, c;
        int e_adv, e_hold, e_data, e_cs, e_dq, e_addr, total;
        logic [AW-1:0] a_v;
        logic [DW-1:0] w_v, base;
        logic [DW-1:0] exp_rd;
        bit in_s, in_h, in_d, in_e;
        bit x_cs, x_oe, x_we, x_adv, x_doe;

        hold_on = mx || (ext && md == 2'd3);
        min_one = hold_on || !ext || ps;
        se = (min_one && s == 0) ? 1 : s;
        he = hold_on ? ((h == 0) ? 1 : h) : 0;
        de = (d == 0) ? 1 : d;
        t  = se + he + de;
        a_v  = AW'(txn_idx * 40503 + 17);
        w_v  = DW'(txn_idx * 7919) ^ 16'h5a3c;
        base = DW'(txn_idx * 97 + 3);
        e_adv = 0; e_hold = 0; e_data = 0; e_cs = 0; e_dq = 0; e_addr = 0;

        @(negedge clk);
        ext_mode_en = ext; mode_sel = md; mux_en = mx; psram_en = ps;
        setup_cyc = 4'(s); hold_cyc = 4'(h); data_cyc = 8'(d);
        wr_en = w; addr = a_v; wdata = w_v; start = 1'b1;

        for (c = 0; c <= t; c++) begin
            @(negedge clk);
            start = 1'b0;
            // R10: stray start pulses while busy
            if ((txn_idx % 2 == 0) && c == 1) begin start = 1'b1; addr = ~a_v; end
            if ((txn_idx % 2 == 1) && c == t) begin start = 1'b1; addr = ~a_v; end
            dq_in = base ^ DW'(c);

            in_s = (c < se);
            in_h = !in_s && (c < se + he);
            in_d = !in_s && !in_h && (c < t);
            in_e = (c == t);
            x_cs  = in_e;
            x_adv = !in_s;
            x_oe  = !(in_d && !w);
            x_we  = !(in_d && w);
            x_doe = (mx && (in_s || in_h)) || (w && in_d);

            if (adv_n !== x_adv) e_adv++;
            if (in_h && (cs_n !== 1'b0 || oe_n !== 1'b1 || we_n !== 1'b1 || adv_n !== 1'b1)) e_hold++;
            if (oe_n !== x_oe || we_n !== x_we) e_data++;
            if (cs_n !== x_cs || done !== in_e || busy !== 1'b1) e_cs++;
            if (dq_oe !== x_doe) e_dq++;
            else if (x_doe && in_d && dq_out !== w_v) e_dq++;
            else if (x_doe && !in_d && dq_out !== DW'(a_v)) e_dq++;
            if (mem_addr !== a_v) e_addr++;
        end

        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b0 && cs_n === 1'b1 && done === 1'b0, "R10 stray start ignored / idle after done",
              int'(busy), 0);

        if (min_one && s == 0) check(e_adv == 0, "R3 setup minimum one cycle", e_adv, 0);
        else                   check(e_adv == 0, "R2 setup length and adv_n", e_adv, 0);
        check(e_hold == 0, "R4 hold phase", e_hold, 0);
        check(e_data == 0, "R5 data phase strobes", e_data, 0);
        check(e_cs == 0, "R6 chip select and done timing", e_cs, 0);
        if (mx) check(e_dq == 0, "R9 multiplexed address on data bus", e_dq, 0);
        else if (w) check(e_dq == 0, "R8 write data drive window", e_dq, 0);
        else        check(e_dq == 0, "R7 read bus released", e_dq, 0);
        check(e_addr == 0, "R9 address bus held", e_addr, 0);
        if (!w) begin
            exp_rd = base ^ DW'(t - 1);
            check(rdata === exp_rd, "R7 read capture on last data cycle", int'(rdata), int'(exp_rd));
        end
        total = e_adv + e_hold + e_data + e_cs + e_dq + e_addr;
        if (!ext && md != 2'd0) check(total == 0, "R11 mode field ignored in basic timing", total, 0);
        txn_idx++;
    endtask

    initial begin
        int sv[5] = '{0, 1, 2, 5, 15};
        int hv[3] = '{0, 1, 3};
        int dv[4] = '{0, 1, 2, 7};
        rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        ext_mode_en = 1'b0; mode_sel = 2'd0; mux_en = 1'b0; psram_en = 1'b0;
        setup_cyc = 4'd15; hold_cyc = 4'd15; data_cyc = 8'd255; dq_in = '0;
        repeat (3) @(negedge clk);
        check(cs_n === 1'b1 && oe_n === 1'b1 && we_n === 1'b1 && adv_n === 1'b1,
              "R1 strobes inactive in reset", int'({cs_n, oe_n, we_n, adv_n}), 15);
        check(busy === 1'b0 && done === 1'b0 && dq_oe === 1'b0 && rdata === '0,
              "R1 status and bus idle in reset", int'({busy, done, dq_oe}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_n === 1'b1 && busy === 1'b0 && dq_oe === 1'b0, "R1 idle after reset release",
              int'({cs_n, busy, dq_oe}), 4);

        for (int ext = 0; ext < 2; ext++)
            for (int md = 0; md < 4; md++)
                for (int mx = 0; mx < 2; mx++)
                    for (int ps = 0; ps < 2; ps++)
                        for (int si = 0; si < 5; si++)
                            for (int hi = 0; hi < 3; hi++)
                                for (int di = 0; di < 4; di++)
                                    for (int w = 0; w < 2; w++)
                                        run_txn(ext[0], 2'(md), mx[0], ps[0], sv[si], hv[hi], dv[di], w[0]);

        // longest phases: mode D, full setup, hold and data lengths
        run_txn(1'b1, 2'd3, 1'b0, 1'b0, 15, 15, 255, 1'b0);
        run_txn(1'b1, 2'd3, 1'b0, 1'b0, 15, 15, 255, 1'b1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R6 watchdog: cycles %0d expected fewer than %0d", 150000, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule